// File: doc/BRIEF.md
# Single-Wire Parasite-Powered Sensor Bus Master

This block drives a shared open-drain data line to which a sensor is attached. The sensor takes its operating power from that same line. A host issues one command at a time: a bus reset with presence detection, a byte write, a byte read, or an explicit strong pull-up hold. The block then produces the matching time slots on the line and sends or receives data least significant bit first. It reports completion with a one-cycle done pulse.

All slot timings are given in microseconds and turned into clock cycles with a clock-frequency parameter. The line is either pulled low or released. A separate enable drives the strong pull-up transistor.

When the byte written is the convert-temperature command (0x44), the block does not finish the final slot. It releases the line at the end of the last bit's low phase and switches on the strong pull-up in that same cycle. The pull-up stays on for a host-programmed number of cycles, so the sensor has power while it converts.

Top module: `sw_bus_master`

## Requirements
- R1: After reset, `busy`, `done`, `line_oe` and `spu_oe` are low, and `line_oe` is only ever high while `busy` is high.
- R2: A reset command (`cmd_op` = 2'b00) holds `line_oe` high for RST_LOW_US×CLK_MHZ cycles. It then releases the line for RST_WAIT_US×CLK_MHZ cycles. `done` is seen (RST_LOW_US+RST_WAIT_US)×CLK_MHZ cycles after the accepting edge.
- R3: `presence` captures the inverted line level PRES_US×CLK_MHZ cycles after the reset release. It reads 1 when a device pulled the line low and 0 when none did.
- R4: A write command (`cmd_op` = 2'b01) sends `cmd_data` as eight slots, bit 0 first.
- R5: In a write slot, a 1 bit drives the line low for W1_LOW_US×CLK_MHZ cycles and a 0 bit for W0_LOW_US×CLK_MHZ cycles. Each slot, recovery included, lasts (SLOT_US+REC_US)×CLK_MHZ cycles.
- R6: A read command (`cmd_op` = 2'b10) drives each slot low for RD_LOW_US×CLK_MHZ cycles. It samples the line RD_SMP_US×CLK_MHZ cycles after the slot starts, which is before 15 µs. The eight samples are assembled into `rd_byte` with bit 0 first.
- R7: Writing 0x44 raises `spu_oe` in the first cycle after the last bit's low phase and holds it for `spu_len` cycles. No other byte raises `spu_oe`.
- R8: During a strong pull-up, `busy` stays high until `spu_oe` falls. For 0x44, `done` is seen (7×slot + W0 low + `spu_len`) cycles after the accepting edge.
- R9: A hold command (`cmd_op` = 2'b11) raises `spu_oe` for exactly `spu_len` cycles (`spu_len` ≥ 1) without driving the line.
- R10: `spu_oe` and `line_oe` are never high in the same cycle.
- R11: A command presented while `busy` is high is ignored and does not alter the operation in progress.
- R12: `done` is a single-cycle pulse at the end of every operation, and `busy` is low in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmd_valid | input | 1 | Command request, taken only when idle |
| cmd_op | input | 2 | 00 reset, 01 write, 10 read, 11 pull-up hold |
| cmd_data | input | 8 | Byte to write |
| spu_len | input | SPU_W | Strong pull-up duration in cycles (≥ 1) |
| line_in | input | 1 | Sampled level of the bus line |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| line_oe | output | 1 | Drive the line low when high |
| spu_oe | output | 1 | Strong pull-up enable |
| rd_byte | output | 8 | Byte assembled by the last read |
| presence | output | 1 | Presence result of the last reset |

## Verification
The assertions assume that `spu_len` is at least one and that `line_in` follows the wire, which is the master drive ORed with the device's open-drain pull-down. The bench models the device as an open-drain pull-down behind a weak pull-up. That device answers a reset with a presence pulse, samples writes 30 µs after each falling edge, and holds read zeros for 15 µs. Requests are normally raised only while `busy` is low. The single deliberate exception is a reset request placed in the middle of a write to test that it is ignored. Pull-up lengths are drawn from 1 to 300 cycles.

// File: rtl/sw_bus_pkg.sv
package sw_bus_pkg;

   typedef enum logic [1:0] {
      OP_RESET = 2'b00,
      OP_WRITE = 2'b01,
      OP_READ  = 2'b10,
      OP_HOLD  = 2'b11
   } sw_op_e;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_RLOW,
      ST_RWAIT,
      ST_WSLOT,
      ST_RSLOT,
      ST_SPU
   } sw_state_e;

   function automatic int us_to_cyc(input int us, input int mhz);
      return us * mhz;
   endfunction

endpackage

// File: rtl/sw_slot_timing.sv
module sw_slot_timing #(
   parameter int CW     = 16,
   parameter int W1_C   = 300,
   parameter int W0_C   = 3000,
   parameter int RDL_C  = 150,
   parameter int RDS_C  = 600,
   parameter int SLOT_C = 3350
) (
   input  logic          in_wslot,
   input  logic          in_rslot,
   input  logic          tx_bit,
   input  logic [CW-1:0] cnt,
   output logic          drive_low,
   output logic          low_last,
   output logic          sample_now,
   output logic          slot_last
);
   localparam logic [CW-1:0] W1_V   = CW'(W1_C);
   localparam logic [CW-1:0] W0_V   = CW'(W0_C);
   localparam logic [CW-1:0] RDL_V  = CW'(RDL_C);
   localparam logic [CW-1:0] RDS_V  = CW'(RDS_C);
   localparam logic [CW-1:0] SLOT_V = CW'(SLOT_C);

   logic          in_slot;
   logic [CW-1:0] low_len;

   always_comb begin
      in_slot    = in_wslot | in_rslot;
      low_len    = in_rslot ? RDL_V : (tx_bit ? W1_V : W0_V);
      drive_low  = in_slot && (cnt < low_len);
      low_last   = in_slot && (cnt == low_len - CW'(1));
      sample_now = in_rslot && (cnt == RDS_V);
      slot_last  = in_slot && (cnt == SLOT_V - CW'(1));
   end
endmodule

// File: rtl/sw_byte_shift.sv
module sw_byte_shift #(
   parameter int BYTE_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load,
   input  logic [BYTE_W-1:0] load_data,
   input  logic              bit_adv,
   input  logic              smp_en,
   input  logic              smp_bit,
   output logic              tx_bit,
   output logic              last_bit,
   output logic [BYTE_W-1:0] rx_byte
);
   localparam int IDX_W = $clog2(BYTE_W);
   localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(BYTE_W - 1);

   logic [BYTE_W-1:0] tx_sh;
   logic [BYTE_W-1:0] rx_sh;
   logic [IDX_W-1:0]  idx;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         tx_sh <= '0;
         rx_sh <= '0;
         idx   <= '0;
      end else begin
         if (load) begin
            tx_sh <= load_data;
            idx   <= '0;
         end else if (bit_adv) begin
            tx_sh <= {1'b0, tx_sh[BYTE_W-1:1]};
            idx   <= idx + IDX_W'(1);
         end
         if (smp_en)
            rx_sh <= {smp_bit, rx_sh[BYTE_W-1:1]};
      end
   end

   assign tx_bit   = tx_sh[0];
   assign last_bit = (idx == LAST_IDX);
   assign rx_byte  = rx_sh;
endmodule

// File: rtl/sw_bus_master.sv
module sw_bus_master
   import sw_bus_pkg::*;
#(
   parameter int          CLK_MHZ     = 50,
   parameter int          RST_LOW_US  = 480,
   parameter int          RST_WAIT_US = 480,
   parameter int          PRES_US     = 70,
   parameter int          SLOT_US     = 65,
   parameter int          REC_US      = 2,
   parameter int          W1_LOW_US   = 6,
   parameter int          W0_LOW_US   = 60,
   parameter int          RD_LOW_US   = 3,
   parameter int          RD_SMP_US   = 12,
   parameter int          SPU_W       = 24,
   parameter bit          AUTO_SPU    = 1'b1,
   parameter logic [7:0]  CONVERT_CMD = 8'h44
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             cmd_valid,
   input  logic [1:0]       cmd_op,
   input  logic [7:0]       cmd_data,
   input  logic [SPU_W-1:0] spu_len,
   input  logic             line_in,
   output logic             busy,
   output logic             done,
   output logic             line_oe,
   output logic             spu_oe,
   output logic [7:0]       rd_byte,
   output logic             presence
);
   localparam int RST_LOW_C  = us_to_cyc(RST_LOW_US, CLK_MHZ);
   localparam int RST_WAIT_C = us_to_cyc(RST_WAIT_US, CLK_MHZ);
   localparam int PRES_C     = us_to_cyc(PRES_US, CLK_MHZ);
   localparam int SLOT_C     = us_to_cyc(SLOT_US + REC_US, CLK_MHZ);
   localparam int W1_C       = us_to_cyc(W1_LOW_US, CLK_MHZ);
   localparam int W0_C       = us_to_cyc(W0_LOW_US, CLK_MHZ);
   localparam int RDL_C      = us_to_cyc(RD_LOW_US, CLK_MHZ);
   localparam int RDS_C      = us_to_cyc(RD_SMP_US, CLK_MHZ);
   localparam int MAX_A      = (RST_LOW_C > RST_WAIT_C) ? RST_LOW_C : RST_WAIT_C;
   localparam int MAX_C      = (MAX_A > SLOT_C) ? MAX_A : SLOT_C;
   localparam int TIM_W      = $clog2(MAX_C + 1);
   localparam int CW         = (TIM_W > SPU_W) ? TIM_W : SPU_W;
   localparam logic [CW-1:0] RST_LOW_V  = CW'(RST_LOW_C);
   localparam logic [CW-1:0] RST_WAIT_V = CW'(RST_WAIT_C);
   localparam logic [CW-1:0] PRES_V     = CW'(PRES_C);

   // elaboration-time parameter checks
   if (CLK_MHZ < 1) begin : g_bad_clk
      $error("CLK_MHZ must be at least 1");
   end
   if (W1_LOW_US >= 15) begin : g_bad_w1
      $error("write-1 low phase must end before 15 us");
   end
   if (W0_LOW_US < 60) begin : g_bad_w0
      $error("write-0 low phase must cover 60 us");
   end
   if (RD_SMP_US >= 15 || RD_LOW_US >= RD_SMP_US) begin : g_bad_rd
      $error("read sample must follow the low phase and precede 15 us");
   end
   if (SLOT_US < W0_LOW_US || REC_US < 1) begin : g_bad_slot
      $error("slot must contain the write-0 low phase plus recovery");
   end
   if (PRES_US >= RST_WAIT_US) begin : g_bad_pres
      $error("presence sample must fall inside the reset wait");
   end

   sw_state_e     state;
   logic [CW-1:0] cnt;
   logic [SPU_W-1:0] spu_q;
   logic          auto_q;
   logic          auto_hit;
   logic [CW-1:0] spu_end;
   logic          accept;
   logic          tx_bit, last_bit;
   logic          drive_low, low_last, sample_now, slot_last;

   if (AUTO_SPU) begin : g_auto
      assign auto_hit = (cmd_data == CONVERT_CMD);
   end else begin : g_noauto
      assign auto_hit = 1'b0;
   end

   assign accept  = cmd_valid && (state == ST_IDLE);
   assign spu_end = CW'(spu_q) - CW'(1);

   sw_slot_timing #(
      .CW(CW), .W1_C(W1_C), .W0_C(W0_C), .RDL_C(RDL_C), .RDS_C(RDS_C), .SLOT_C(SLOT_C)
   ) u_timing (
      .in_wslot  (state == ST_WSLOT),
      .in_rslot  (state == ST_RSLOT),
      .tx_bit    (tx_bit),
      .cnt       (cnt),
      .drive_low (drive_low),
      .low_last  (low_last),
      .sample_now(sample_now),
      .slot_last (slot_last)
   );

   sw_byte_shift #(.BYTE_W(8)) u_shift (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (accept && (cmd_op == OP_WRITE || cmd_op == OP_READ)),
      .load_data(cmd_data),
      .bit_adv  (slot_last),
      .smp_en   (sample_now),
      .smp_bit  (line_in),
      .tx_bit   (tx_bit),
      .last_bit (last_bit),
      .rx_byte  (rd_byte)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state    <= ST_IDLE;
         cnt      <= '0;
         spu_q    <= '0;
         auto_q   <= 1'b0;
         done     <= 1'b0;
         presence <= 1'b0;
      end else begin
         done <= 1'b0;
         unique case (state)
            ST_IDLE: begin
               if (accept) begin
                  cnt    <= '0;
                  spu_q  <= spu_len;
                  auto_q <= (cmd_op == OP_WRITE) && auto_hit;
                  unique case (sw_op_e'(cmd_op))
                     OP_RESET: state <= ST_RLOW;
                     OP_WRITE: state <= ST_WSLOT;
                     OP_READ:  state <= ST_RSLOT;
                     OP_HOLD:  state <= ST_SPU;
                  endcase
               end
            end
            ST_RLOW: begin
               if (cnt == RST_LOW_V - CW'(1)) begin
                  state <= ST_RWAIT;
                  cnt   <= '0;
               end else cnt <= cnt + CW'(1);
            end
            ST_RWAIT: begin
               if (cnt == PRES_V) presence <= !line_in;
               if (cnt == RST_WAIT_V - CW'(1)) begin
                  state <= ST_IDLE;
                  done  <= 1'b1;
               end else cnt <= cnt + CW'(1);
            end
            ST_WSLOT, ST_RSLOT: begin
               if ((state == ST_WSLOT) && auto_q && last_bit && low_last) begin
                  state <= ST_SPU;
                  cnt   <= '0;
               end else if (slot_last) begin
                  cnt <= '0;
                  if (last_bit) begin
                     state <= ST_IDLE;
                     done  <= 1'b1;
                  end
               end else cnt <= cnt + CW'(1);
            end
            ST_SPU: begin
               if (cnt == spu_end) begin
                  state <= ST_IDLE;
                  done  <= 1'b1;
               end else cnt <= cnt + CW'(1);
            end
            default: state <= ST_IDLE;
         endcase
      end
   end

   assign busy    = (state != ST_IDLE);
   assign line_oe = (state == ST_RLOW) || drive_low;
   assign spu_oe  = (state == ST_SPU);
endmodule

// File: rtl/sw_bus_master_chk.sv
module sw_bus_master_chk (
   input logic clk,
   input logic rst_n,
   input logic cmd_valid,
   input logic busy,
   input logic done,
   input logic line_oe,
   input logic spu_oe
);
   assert_line_busy_R1: assert property (@(posedge clk) disable iff (!rst_n)
      line_oe |-> busy);

   assert_spu_busy_R8: assert property (@(posedge clk) disable iff (!rst_n)
      spu_oe |-> busy);

   assert_no_overlap_R10: assert property (@(posedge clk) disable iff (!rst_n)
      !(spu_oe && line_oe));

   assert_start_req_R11: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy) |-> $past(cmd_valid));

   assert_done_end_R12: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> (!busy && $past(busy)));

   assert_done_pulse_R12: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);
endmodule

bind sw_bus_master sw_bus_master_chk i_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .cmd_valid(cmd_valid),
   .busy     (busy),
   .done     (done),
   .line_oe  (line_oe),
   .spu_oe   (spu_oe)
);

// File: tb/test_sw_bus_master.sv
module test_sw_bus_master;
   localparam int CLK_MHZ = 2;
   localparam int SLOT_C  = (65 + 2) * CLK_MHZ;
   localparam int W1_C    = 6 * CLK_MHZ;
   localparam int W0_C    = 60 * CLK_MHZ;
   localparam int RDL_C   = 3 * CLK_MHZ;
   localparam int RLOW_C  = 480 * CLK_MHZ;
   localparam int RWAIT_C = 480 * CLK_MHZ;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cmd_valid = 1'b0;
   logic [1:0]  cmd_op = 2'b00;
   logic [7:0]  cmd_data = 8'h00;
   logic [23:0] spu_len = 24'd1;
   logic        line_in;
   logic        busy, done, line_oe, spu_oe, presence;
   logic [7:0]  rd_byte;

   int checks = 0;
   int errors = 0;

   // device model state
   logic       slv_low_rd = 1'b0;
   logic       slv_low_pr = 1'b0;
   bit         present_en = 1'b1;
   int         mode = 0;
   logic [7:0] slv_rx = 8'h00;
   logic [7:0] slv_tx = 8'h00;
   int         tx_idx = 0;
   int         since_fall = 1000000;
   int         pres_cnt = 1000000;
   bit         prev_oe = 1'b0;
   bit         prev_spu = 1'b0;
   bit         spu_prev_oe = 1'b0;
   int         mlow = 0;
   int         srun = 0;
   int         overlap = 0;
   int         lows[$];
   int         spus[$];

   assign line_in = !(line_oe || slv_low_rd || slv_low_pr);

   always #10 clk = ~clk;

   sw_bus_master #(.CLK_MHZ(CLK_MHZ)) i_sw_bus_master (
      .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
      .cmd_data(cmd_data), .spu_len(spu_len), .line_in(line_in),
      .busy(busy), .done(done), .line_oe(line_oe), .spu_oe(spu_oe),
      .rd_byte(rd_byte), .presence(presence)
   );

   always @(negedge clk) begin
      if (spu_oe && line_oe) overlap++;
      if (spu_oe && !prev_spu) spu_prev_oe = prev_oe;
      if (spu_oe) srun++;
      else if (srun > 0) begin spus.push_back(srun); srun = 0; end
      if (line_oe) mlow++;
      else if (mlow > 0) begin
         lows.push_back(mlow);
         if (mlow >= 800 && present_en) pres_cnt = 0;
         mlow = 0;
      end
      if (line_oe && !prev_oe) begin
         since_fall = 0;
         if (mode == 1 && tx_idx < 8) slv_low_rd = !slv_tx[tx_idx];
      end else if (since_fall < 1000000) since_fall++;
      if (mode == 1 && since_fall == 30) begin
         slv_low_rd = 1'b0;
         tx_idx++;
      end
      if (mode == 0 && since_fall == 60) slv_rx = {line_in, slv_rx[7:1]};
      if (pres_cnt == 30) slv_low_pr = 1'b1;
      if (pres_cnt == 270) slv_low_pr = 1'b0;
      if (pres_cnt < 1000000) pres_cnt++;
      prev_oe  = line_oe;
      prev_spu = spu_oe;
   end

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   function automatic int exp_low(input logic b);
      return b ? W1_C : W0_C;
   endfunction

   task automatic run_op(input logic [1:0] op, input logic [7:0] d, input int len, output int dur);
      @(negedge clk);
      cmd_valid = 1'b1; cmd_op = op; cmd_data = d; spu_len = 24'(len);
      @(negedge clk);
      cmd_valid = 1'b0;
      dur = 0;
      while (!done && dur < 20000) begin @(negedge clk); dur++; end
      chk(done && !busy, "R12 done with busy low", int'(busy), 0);
      @(negedge clk);
      chk(!done, "R12 done lasts one cycle", int'(done), 0);
   endtask

   task automatic do_reset_op(input bit present);
      int dur;
      present_en = present; mode = 0; lows.delete();
      run_op(2'b00, 8'h00, 1, dur);
      chk(dur == RLOW_C + RWAIT_C, "R2 reset duration", dur, RLOW_C + RWAIT_C);
      chk(lows.size() == 1 && lows[0] == RLOW_C, "R2 reset low width",
          (lows.size() > 0) ? lows[0] : -1, RLOW_C);
      chk(presence == present, "R3 presence", int'(presence), int'(present));
   endtask

   task automatic do_write(input logic [7:0] d, input int len);
      int  dur;
      bit  is_conv;
      int  bad;
      is_conv = (d == 8'h44);
      mode = 0; slv_rx = 8'h00; lows.delete(); spus.delete(); bad = 0;
      run_op(2'b01, d, len, dur);
      chk(slv_rx == d, "R4 byte seen by device", int'(slv_rx), int'(d));
      for (int i = 0; i < 8; i++)
         if (i >= lows.size() || lows[i] != exp_low(d[i])) bad++;
      chk(lows.size() == 8 && bad == 0, "R5 write low widths", bad, 0);
      if (is_conv) begin
         chk(dur == 7 * SLOT_C + W0_C + len, "R8 busy through pull-up", dur, 7 * SLOT_C + W0_C + len);
         chk(spus.size() == 1 && spus[0] == len, "R7 pull-up length",
             (spus.size() > 0) ? spus[0] : -1, len);
         chk(spu_prev_oe == 1'b1, "R7 pull-up follows last low phase", int'(spu_prev_oe), 1);
      end else begin
         chk(dur == 8 * SLOT_C, "R5 write duration", dur, 8 * SLOT_C);
         chk(spus.size() == 0, "R7 no pull-up for other byte", spus.size(), 0);
      end
   endtask

   task automatic do_read(input logic [7:0] d);
      int dur;
      int bad;
      mode = 1; slv_tx = d; tx_idx = 0; lows.delete(); bad = 0;
      run_op(2'b10, 8'h00, 1, dur);
      mode = 0;
      chk(rd_byte == d, "R6 read byte", int'(rd_byte), int'(d));
      foreach (lows[i]) if (lows[i] != RDL_C) bad++;
      chk(lows.size() == 8 && bad == 0, "R6 read low widths", bad, 0);
      chk(dur == 8 * SLOT_C, "R6 read duration", dur, 8 * SLOT_C);
   endtask

   task automatic do_hold(input int len);
      int dur;
      mode = 0; lows.delete(); spus.delete();
      run_op(2'b11, 8'h00, len, dur);
      chk(dur == len, "R9 hold duration", dur, len);
      chk(spus.size() == 1 && spus[0] == len, "R9 hold pull-up length",
          (spus.size() > 0) ? spus[0] : -1, len);
      chk(lows.size() == 0 && spu_prev_oe == 1'b0, "R9 line not driven", lows.size(), 0);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      errors++;
      checks++;
      $display("FAIL watchdog all requirements actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      int dur;
      void'($urandom(32'd20240611));
      repeat (3) @(negedge clk);
      chk(!busy && !done && !line_oe && !spu_oe, "R1 reset state",
          int'({busy, done, line_oe, spu_oe}), 0);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);

      do_reset_op(1'b1);
      do_reset_op(1'b0);
      do_reset_op(1'b1);

      // directed bytes
      do_write(8'hCC, 1);
      do_write(8'h00, 1);
      do_write(8'hFF, 1);
      do_write(8'h44, 1);
      do_read(8'h00);
      do_read(8'hFF);
      do_hold(1);

      // constrained random traffic
      for (int i = 0; i < 6; i++) begin
         logic [7:0] b;
         b = 8'($urandom_range(0, 255));
         if (b == 8'h44) b = 8'h45;
         do_write(b, 1);
      end
      for (int i = 0; i < 6; i++) do_read(8'($urandom_range(0, 255)));
      for (int i = 0; i < 3; i++) do_hold(int'($urandom_range(1, 300)));
      for (int i = 0; i < 2; i++) do_write(8'h44, int'($urandom_range(1, 300)));

      // R11: a reset request in the middle of a write is ignored
      mode = 0; slv_rx = 8'h00; lows.delete();
      fork
         run_op(2'b01, 8'hA5, 1, dur);
         begin
            repeat (200) @(negedge clk);
            cmd_valid = 1'b1; cmd_op = 2'b00;
            @(negedge clk);
            cmd_valid = 1'b0;
         end
      join
      chk(slv_rx == 8'hA5, "R11 write unaffected by request", int'(slv_rx), 'hA5);
      chk(dur == 8 * SLOT_C && lows.size() == 8, "R11 no extra activity", dur, 8 * SLOT_C);
      repeat (20) @(negedge clk);
      chk(!busy && !line_oe, "R11 stays idle after ignored request", int'(busy), 0);

      chk(overlap == 0, "R10 pull-up never with low drive", overlap, 0);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule